// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a supervisory countdown timer that software services through a small synchronous register port. Software programs a reload value and starts the count by clearing a halt bit. After that it must keep restarting the count by writing a nonzero key to a restart register. Without those restarts the counter runs down once per tick-enable pulse. The first expiry raises a sticky first-stage flag, which can drive an interrupt. A second expiry while that flag is still set raises a second-stage flag and a one-cycle system reset request.

The reset request can be blocked by a no-reboot lock bit. This bit is set out of reset. Software releases it by writing 0 and confirms the release by reading the bit back. A strap input can hold the lock on regardless of what software writes. All status flags are sticky: hardware sets them, and software clears each one by writing 1 to its position.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset: the timer register reads 4, the count reads 4, the control register reads 0x0800 (halted), both status registers read 0, the interrupt enable reads 0, the no-reboot lock reads 1, and `irq` and `rst_req` are low.
- R2: A write to the timer register (address 0) stores bits [9:0]. Bits [15:10] are ignored and read as 0. The write does not change the running count.
- R3: A write to the restart register (address 1) loads the count from the stored timer value only if bits [4:0] of the write data are nonzero. A write with those bits all zero has no effect. A read of address 1 returns the current count.
- R4: While control bit 11 (halt) is 1, tick pulses leave the count unchanged. While it is 0, each cycle with `tick_en` high lowers the count by one. Cycles without `tick_en` leave the count unchanged.
- R5: Control bit 9 is a read/write bit that is written independently of halt. Every other control bit reads as 0.
- R6: A stored timer value below 2 loads a count of 2.
- R7: A tick that arrives when the count is 1 is an expiry. The count reloads from the timer value, so one period is max(value,2) ticks. If status-1 bit 3 (first stage) is clear, the expiry sets it.
- R8: Status flags (status-1 at address 3 bit 3; status-2 at address 4, bits 1 and 2) clear only when software writes 1 to their own bit. Writing 0 leaves them set. A hardware set in the same cycle as a clear wins.
- R9: `irq` is high exactly while the first-stage flag is set and interrupt-enable bit 0 (address 5) is 1.
- R10: An expiry while the first-stage flag is set sets status-2 bit 1 (second stage). It also pulses `rst_req` high for exactly one cycle, unless the no-reboot lock is in effect.
- R11: A second-stage expiry that happens before any restart since reset also sets status-2 bit 2 (boot flag).
- R12: No-reboot (address 6 bit 0) resets to 1 and is written by software. It reads back as the stored bit OR `strap_no_reboot`. While it reads 1, `rst_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| tick_en | input | 1 | One countdown step per high cycle |
| strap_no_reboot | input | 1 | Forces the no-reboot lock on |
| irq | output | 1 | First-stage interrupt request |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A wrong count shows up at the next read of address 1, and it shows up one tick late or early at the flag that expiry sets. A lost or leaked status flag is visible on the next status read, and on `irq` in the same cycle. A wrong stage decision or a wrong lock state shows up as a missing, extra or stretched `rst_req` pulse in the cycle after the expiring tick. The bench sweeps small timer values tick by tick and compares every count against max(value,2) minus the ticks elapsed.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   // register addresses
   localparam int A_TIMER    = 0;
   localparam int A_RESTART  = 1;
   localparam int A_CTRL     = 2;
   localparam int A_STS1     = 3;
   localparam int A_STS2     = 4;
   localparam int A_IRQEN    = 5;
   localparam int A_NOREBOOT = 6;
   // bit positions
   localparam int B_HALT     = 11;
   localparam int B_KEEP     = 9;
   localparam int B_FIRST    = 3;
   localparam int B_SECOND   = 1;
   localparam int B_BOOT     = 2;
   localparam int B_IRQEN    = 0;
   localparam int B_NOREBOOT = 0;
   localparam int KEY_W      = 5;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 3,
   parameter int TMR_W     = 10,
   parameter int RST_TMR   = 4,
   parameter int MIN_TICKS = 2,
   parameter bit HAS_STRAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              strap_nr,
   input  logic              set_first,
   input  logic              set_second,
   input  logic              set_boot,
   input  logic [TMR_W-1:0]  cnt,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [TMR_W-1:0]  load_val,
   output logic              load_stb,
   output logic              halt,
   output logic              irq_en,
   output logic              nr_eff,
   output logic              first_flag,
   output logic              second_flag,
   output logic              boot_flag
);
   logic [TMR_W-1:0] tmr_q;
   logic             keep_q;
   logic             nr_q;
   logic             wr_timer, wr_restart, wr_ctrl, wr_sts1, wr_sts2, wr_irqen, wr_nr;
   logic             unused_wdata;

   assign unused_wdata = ^reg_wdata;

   assign wr_timer   = reg_wr && (reg_addr == ADDR_W'(A_TIMER));
   assign wr_restart = reg_wr && (reg_addr == ADDR_W'(A_RESTART));
   assign wr_ctrl    = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
   assign wr_sts1    = reg_wr && (reg_addr == ADDR_W'(A_STS1));
   assign wr_sts2    = reg_wr && (reg_addr == ADDR_W'(A_STS2));
   assign wr_irqen   = reg_wr && (reg_addr == ADDR_W'(A_IRQEN));
   assign wr_nr      = reg_wr && (reg_addr == ADDR_W'(A_NOREBOOT));

   assign load_stb = wr_restart && (|reg_wdata[KEY_W-1:0]);
   assign load_val = (tmr_q < TMR_W'(MIN_TICKS)) ? TMR_W'(MIN_TICKS) : tmr_q;

   generate
      if (HAS_STRAP) begin : g_strap
         assign nr_eff = nr_q | strap_nr;
      end else begin : g_nostrap
         logic unused_strap;
         assign unused_strap = strap_nr;
         assign nr_eff = nr_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tmr_q       <= TMR_W'(RST_TMR);
         halt        <= 1'b1;
         keep_q      <= 1'b0;
         irq_en      <= 1'b0;
         nr_q        <= 1'b1;
         first_flag  <= 1'b0;
         second_flag <= 1'b0;
         boot_flag   <= 1'b0;
      end else begin
         if (wr_timer) tmr_q <= reg_wdata[TMR_W-1:0];
         if (wr_ctrl) begin
            halt   <= reg_wdata[B_HALT];
            keep_q <= reg_wdata[B_KEEP];
         end
         if (wr_irqen) irq_en <= reg_wdata[B_IRQEN];
         if (wr_nr)    nr_q   <= reg_wdata[B_NOREBOOT];
         first_flag  <= set_first  | (first_flag  & ~(wr_sts1 & reg_wdata[B_FIRST]));
         second_flag <= set_second | (second_flag & ~(wr_sts2 & reg_wdata[B_SECOND]));
         boot_flag   <= set_boot   | (boot_flag   & ~(wr_sts2 & reg_wdata[B_BOOT]));
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(A_TIMER))    reg_rdata[TMR_W-1:0] = tmr_q;
      if (reg_addr == ADDR_W'(A_RESTART))  reg_rdata[TMR_W-1:0] = cnt;
      if (reg_addr == ADDR_W'(A_CTRL)) begin
         reg_rdata[B_HALT] = halt;
         reg_rdata[B_KEEP] = keep_q;
      end
      if (reg_addr == ADDR_W'(A_STS1))     reg_rdata[B_FIRST] = first_flag;
      if (reg_addr == ADDR_W'(A_STS2)) begin
         reg_rdata[B_SECOND] = second_flag;
         reg_rdata[B_BOOT]   = boot_flag;
      end
      if (reg_addr == ADDR_W'(A_IRQEN))    reg_rdata[B_IRQEN]    = irq_en;
      if (reg_addr == ADDR_W'(A_NOREBOOT)) reg_rdata[B_NOREBOOT] = nr_eff;
   end
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
   parameter int TMR_W   = 10,
   parameter int RST_VAL = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             halt,
   input  logic             load,
   input  logic [TMR_W-1:0] load_val,
   output logic [TMR_W-1:0] cnt,
   output logic             expire
);
   logic run;

   assign run    = tick && !halt;
   assign expire = run && !load && (cnt == TMR_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt <= TMR_W'(RST_VAL);
      else if (load)    cnt <= load_val;
      else if (expire)  cnt <= load_val;
      else if (run)     cnt <= cnt - TMR_W'(1);
   end
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic first_flag,
   input  logic load_stb,
   input  logic nr_eff,
   output logic set_first,
   output logic set_second,
   output logic set_boot,
   output logic rst_req
);
   logic restarted_q;

   assign set_first  = expire && !first_flag;
   assign set_second = expire && first_flag;
   assign set_boot   = set_second && !restarted_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         restarted_q <= 1'b0;
         rst_req     <= 1'b0;
      end else begin
         if (load_stb) restarted_q <= 1'b1;
         rst_req <= set_second && !nr_eff;
      end
   end
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 3,
   parameter int TMR_W     = 10,
   parameter int RST_TMR   = 4,
   parameter int MIN_TICKS = 2,
   parameter bit HAS_STRAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              tick_en,
   input  logic              strap_no_reboot,
   output logic              irq,
   output logic              rst_req
);
   localparam int RST_EFF = (RST_TMR < MIN_TICKS) ? MIN_TICKS : RST_TMR;

   generate
      if (DATA_W < 12)               begin : g_bad_data  $error("DATA_W too small for control bits"); end
      if (TMR_W > DATA_W)            begin : g_bad_tmr   $error("TMR_W exceeds DATA_W"); end
      if (TMR_W < 5)                 begin : g_bad_tmr2  $error("TMR_W too small for restart key"); end
      if (ADDR_W < 3)                begin : g_bad_addr  $error("ADDR_W must cover 7 registers"); end
      if (MIN_TICKS < 2)             begin : g_bad_min   $error("MIN_TICKS must be at least 2"); end
      if (RST_EFF >= (1 << TMR_W))   begin : g_bad_rst   $error("RST_TMR does not fit TMR_W"); end
   endgenerate

   logic [TMR_W-1:0] cnt, load_val;
   logic load_stb, halt, irq_en, nr_eff;
   logic first_flag, second_flag, boot_flag;
   logic set_first, set_second, set_boot, expire;

   wdt_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TMR_W(TMR_W),
      .RST_TMR(RST_TMR), .MIN_TICKS(MIN_TICKS), .HAS_STRAP(HAS_STRAP)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .strap_nr(strap_no_reboot),
      .set_first(set_first), .set_second(set_second), .set_boot(set_boot),
      .cnt(cnt), .reg_rdata(reg_rdata), .load_val(load_val), .load_stb(load_stb),
      .halt(halt), .irq_en(irq_en), .nr_eff(nr_eff), .first_flag(first_flag),
      .second_flag(second_flag), .boot_flag(boot_flag)
   );

   wdt_count #(.TMR_W(TMR_W), .RST_VAL(RST_EFF)) u_count (
      .clk(clk), .rst_n(rst_n), .tick(tick_en), .halt(halt), .load(load_stb),
      .load_val(load_val), .cnt(cnt), .expire(expire)
   );

   wdt_stage u_stage (
      .clk(clk), .rst_n(rst_n), .expire(expire), .first_flag(first_flag),
      .load_stb(load_stb), .nr_eff(nr_eff), .set_first(set_first),
      .set_second(set_second), .set_boot(set_boot), .rst_req(rst_req)
   );

   assign irq = first_flag && irq_en;
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
   parameter int TMR_W     = 10,
   parameter int MIN_TICKS = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [TMR_W-1:0] cnt,
   input logic             load,
   input logic             halt,
   input logic             expire,
   input logic             first,
   input logic             second,
   input logic             irq,
   input logic             irq_en,
   input logic             rst_req,
   input logic             nr_eff
);
   AST_RST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req); // R10
   AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> !$past(nr_eff)); // R12
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> irq_en); // R9
   AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cnt != '0); // R6
   AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !load) |=> $stable(cnt)); // R4
   AST_RELOAD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt >= TMR_W'(MIN_TICKS))); // R3
   AST_FIRST_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(first) |-> $past(expire)); // R7
   AST_SECOND_AFTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(second) |-> $past(first)); // R10
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.TMR_W(TMR_W), .MIN_TICKS(MIN_TICKS)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt(cnt), .load(load_stb), .halt(halt),
   .expire(expire), .first(first_flag), .second(second_flag), .irq(irq),
   .irq_en(irq_en), .rst_req(rst_req), .nr_eff(nr_eff)
);

// File: tb/wdt_two_stage_tb.sv
`timescale 1ns/1ps
module wdt_two_stage_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        tick_en = 1'b0;
   logic        strap_no_reboot = 1'b0;
   logic        irq, rst_req;

   int checks = 0;
   int fails = 0;
   int pulses = 0;
   bit done = 0;

   always #5 clk = ~clk;

   wdt_two_stage u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_en(tick_en),
      .strap_no_reboot(strap_no_reboot), .irq(irq), .rst_req(rst_req)
   );

   always @(negedge clk) if (rst_req) pulses++;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      reg_addr = 3'(a); reg_wdata = 16'(d); reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      reg_addr = 3'(a);
      #1;
      d = int'(reg_rdata);
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         tick_en = 1'b1;
         @(negedge clk);
         tick_en = 1'b0;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      int v;
      int exp;
      @(negedge clk);
      do_reset();
      // R1 reset state
      rd(0, v); check("R1 timer", v, 4);
      rd(1, v); check("R1 count", v, 4);
      rd(2, v); check("R1 ctrl", v, 16'h0800);
      rd(3, v); check("R1 sts1", v, 0);
      rd(4, v); check("R1 sts2", v, 0);
      rd(5, v); check("R1 irqen", v, 0);
      rd(6, v); check("R1 noreboot", v, 1);
      check("R1 irq", int'(irq), 0);
      check("R1 rst_req", int'(rst_req), 0);
      // R4 halted
      tick(5);
      rd(1, v); check("R4 halted count", v, 4);
      // R2 timer write
      wr(0, 16'hFC07);
      rd(0, v); check("R2 timer masked", v, 7);
      rd(1, v); check("R2 no restart", v, 4);
      // R3 restart key
      wr(1, 16'h0020);
      rd(1, v); check("R3 zero key ignored", v, 4);
      wr(1, 16'h0010);
      rd(1, v); check("R3 restart loads", v, 7);
      // R5 control bits
      wr(2, 16'hFFFF);
      rd(2, v); check("R5 ctrl readback", v, 16'h0A00);
      tick(1);
      rd(1, v); check("R4 still halted", v, 7);
      wr(2, 16'h0200);
      rd(2, v); check("R5 keep bit alone", v, 16'h0200);
      tick(1);
      rd(1, v); check("R4 running tick", v, 6);
      repeat (3) @(negedge clk);
      rd(1, v); check("R4 no tick no change", v, 6);
      wr(2, 0);
      rd(2, v); check("R5 ctrl cleared", v, 0);
      // R6/R3/R4 sweep of small timer values
      for (int t = 0; t < 13; t++) begin
         wr(0, t);
         wr(1, 1);
         exp = (t < 2) ? 2 : t;
         rd(1, v); check("R6 restart value", v, exp);
         for (int k = 1; k < exp; k++) begin
            tick(1);
            rd(1, v); check("R4 sweep count", v, exp - k);
         end
      end
      rd(3, v); check("R7 no expiry in sweep", v, 0);
      // R7 first stage
      wr(0, 3);
      wr(1, 1);
      tick(2);
      rd(1, v); check("R4 before expiry", v, 1);
      tick(1);
      rd(3, v); check("R7 first flag", v, 16'h0008);
      rd(1, v); check("R7 reload on expiry", v, 3);
      rd(4, v); check("R7 no second yet", v, 0);
      check("R9 irq disabled", int'(irq), 0);
      wr(5, 1);
      check("R9 irq enabled", int'(irq), 1);
      wr(3, 0);
      rd(3, v); check("R8 write zero keeps", v, 16'h0008);
      wr(3, 16'h0008);
      rd(3, v); check("R8 w1c clears", v, 0);
      check("R9 irq follows flag", int'(irq), 0);
      tick(3);
      rd(3, v); check("R7 rearmed", v, 16'h0008);
      // R10/R11/R12 second stage under lock
      tick(3);
      @(negedge clk);
      rd(4, v); check("R10 second flag no boot R11", v, 16'h0002);
      check("R12 locked no pulse", pulses, 0);
      wr(6, 0);
      rd(6, v); check("R12 lock released", v, 0);
      strap_no_reboot = 1'b1;
      rd(6, v); check("R12 strap forces", v, 1);
      tick(3);
      @(negedge clk);
      check("R12 strap blocks", pulses, 0);
      strap_no_reboot = 1'b0;
      rd(6, v); check("R12 strap released", v, 0);
      wr(4, 16'h0002);
      rd(4, v); check("R8 sts2 cleared", v, 0);
      tick(3);
      @(negedge clk);
      rd(4, v); check("R10 second again", v, 16'h0002);
      check("R10 one pulse", pulses, 1);
      repeat (2) @(negedge clk);
      check("R10 pulse one cycle", pulses, 1);
      // R11 boot flag
      do_reset();
      wr(6, 0);
      wr(2, 0);
      tick(4);
      rd(3, v); check("R7 first after reset", v, 16'h0008);
      check("R9 irq off after reset", int'(irq), 0);
      tick(4);
      @(negedge clk);
      rd(4, v); check("R11 boot flag", v, 16'h0006);
      check("R10 pulse after reset", pulses, 2);
      wr(4, 16'h0004);
      rd(4, v); check("R8 boot clear alone", v, 16'h0002);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(negedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule